// File: doc/BRIEF.md
# Exception entry sequencer

This block performs the memory traffic a processor core needs when it enters an exception. The core gives it a start strobe, the kind of exception, a vector number and the current program counter, status word and stack pointer. For either reset kind the block reads the starting program counter and the starting stack pointer from a vector table and leaves the stack alone. For an interrupt it first stores the status word and then the program counter on a downward-growing stack. It then reads the handler address from the vector table and reports the lowered stack pointer.

All traffic uses one single-word port. The block holds a request until it is acknowledged. When the last access has completed, a done strobe tells the core that the new program counter and stack pointer are valid, and execution resumes at that program counter. The block does not choose between competing exceptions and does not perform the return from an exception.

Top module: `exc_seq`

## Requirements
- R1: While reset is applied and after it is released, mem_req_o, done_o, pc_o and sp_o are all zero until a sequence is started.
- R2: The encoding of kind_i is 0 for power-on reset, 1 for manual reset and 2 for interrupt, and the reserved value 3 behaves like 0. A power-on reset issues exactly two reads and no writes. The first read is at VEC_BASE and is loaded into pc_o. The second read is at VEC_BASE+4 and is loaded into sp_o.
- R3: A manual reset issues two reads and no writes. The read at VEC_BASE+8 is loaded into pc_o and the read at VEC_BASE+12 is loaded into sp_o.
- R4: An interrupt first writes sr_i to address sp_i-4, and then writes pc_i to address sp_i-8. Both writes use the values captured at start.
- R5: After its two writes, an interrupt reads VEC_BASE + 4*vec_i and loads the result into pc_o. At completion sp_o equals the captured sp_i minus 8.
- R6: An access completes at a rising edge where both mem_req_o and mem_ack_i are high. Until then mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold steady. The next access of the same sequence is presented in the following cycle.
- R7: done_o is high for exactly one cycle, the cycle right after the final access completes. mem_req_o is low in that cycle, and pc_o and sp_o already hold their final values.
- R8: A start_i received while a sequence is running, including its done cycle, is ignored. The sequence in progress continues with the inputs it captured.
- R9: A start_i accepted while idle makes mem_req_o high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exception entry sequence |
| kind_i | input | 2 | Exception kind: 0 power-on, 1 manual reset, 2 interrupt |
| vec_i | input | VEC_W | Vector number for an interrupt |
| pc_i | input | XLEN | Program counter to save |
| sr_i | input | XLEN | Status word to save |
| sp_i | input | XLEN | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | XLEN | Byte address of the word |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| pc_o | output | XLEN | Loaded program counter |
| sp_o | output | XLEN | Loaded or lowered stack pointer |
| done_o | output | 1 | Sequence finished strobe |

## Verification
The bench builds the block with XLEN of 32, VEC_W of 8 and a non-zero VEC_BASE of 0x10000. A table base that is dropped or added in the wrong place is therefore visible on every read address. Vector 255 drives the vector field to its top value, so a truncated scaling of the vector number shows up in the address. Interrupts are also run with a stack pointer near zero, where the subtraction wraps. The acknowledge is given either at once or after random wait cycles, which exercises both back-to-back accesses and held requests.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_POR = 2'd0,
    KIND_MAN = 2'd1,
    KIND_IRQ = 2'd2
  } exc_kind_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_PC   = 2'd1,
    DST_SP   = 2'd2
  } exc_dst_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } exc_st_e;
endpackage

// File: rtl/exc_seq_plan.sv
// Per-step access description, purely combinational.
module exc_seq_plan
  import exc_seq_pkg::*;
#(
  parameter int unsigned      XLEN     = 32,
  parameter int unsigned      VEC_W    = 8,
  parameter logic [XLEN-1:0]  VEC_BASE = '0
) (
  input  exc_kind_e        kind_i,
  input  logic [1:0]       step_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             we_o,
  output logic [XLEN-1:0]  wdata_o,
  output exc_dst_e         dst_o,
  output logic             last_o,
  output logic [XLEN-1:0]  sp_fin_o
);
  localparam int unsigned    WORD_B = XLEN / 8;
  localparam logic [XLEN-1:0] W1 = XLEN'(WORD_B);
  localparam logic [XLEN-1:0] W2 = XLEN'(2 * WORD_B);
  localparam logic [XLEN-1:0] W3 = XLEN'(3 * WORD_B);

  logic [XLEN-1:0] vec_addr;
  assign vec_addr = VEC_BASE + (XLEN'(vec_i) * W1);
  assign sp_fin_o = sp_i - W2;

  always_comb begin
    addr_o  = VEC_BASE;
    we_o    = 1'b0;
    wdata_o = '0;
    dst_o   = DST_NONE;
    last_o  = 1'b0;
    case (kind_i)
      KIND_IRQ: begin
        case (step_i)
          2'd0: begin
            we_o    = 1'b1;
            addr_o  = sp_i - W1;
            wdata_o = sr_i;
          end
          2'd1: begin
            we_o    = 1'b1;
            addr_o  = sp_i - W2;
            wdata_o = pc_i;
          end
          default: begin
            addr_o = vec_addr;
            dst_o  = DST_PC;
            last_o = 1'b1;
          end
        endcase
      end
      KIND_MAN: begin
        if (step_i == 2'd0) begin
          addr_o = VEC_BASE + W2;
          dst_o  = DST_PC;
        end else begin
          addr_o = VEC_BASE + W3;
          dst_o  = DST_SP;
          last_o = 1'b1;
        end
      end
      default: begin
        if (step_i == 2'd0) begin
          addr_o = VEC_BASE;
          dst_o  = DST_PC;
        end else begin
          addr_o = VEC_BASE + W1;
          dst_o  = DST_SP;
          last_o = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/exc_seq_ctl.sv
module exc_seq_ctl
  import exc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ack_i,
  input  logic       last_i,
  output logic       launch_o,
  output logic       fire_o,
  output logic       req_o,
  output logic       done_o,
  output logic [1:0] step_o
);
  exc_st_e    st_q;
  logic [1:0] step_q;

  assign req_o    = (st_q == ST_ACC);
  assign done_o   = (st_q == ST_FIN);
  assign launch_o = (st_q == ST_IDLE) && start_i;
  assign fire_o   = req_o && ack_i;
  assign step_o   = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_ACC;
          step_q <= '0;
        end
        ST_ACC: if (ack_i) begin
          if (last_i) st_q <= ST_FIN;
          else        step_q <= step_q + 2'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_seq_load.sv
module exc_seq_load
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            we_i,
  input  exc_dst_e        dst_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic            sp_set_i,
  input  logic [XLEN-1:0] sp_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o <= '0;
      sp_o <= '0;
    end else begin
      if (fire_i && !we_i) begin
        if (dst_i == DST_PC) pc_o <= rdata_i;
        if (dst_i == DST_SP) sp_o <= rdata_i;
      end
      if (sp_set_i) sp_o <= sp_val_i;
    end
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     VEC_W    = 8,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ack_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sp_o,
  output logic             done_o
);
  exc_kind_e        kind_q;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  pc_q, sr_q, sp_q;

  logic       launch, fire, last;
  logic [1:0] step;
  exc_dst_e   dst;
  logic [XLEN-1:0] sp_fin;

  // Context captured once per sequence; later starts never reach it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= KIND_POR;
      vec_q  <= '0;
      pc_q   <= '0;
      sr_q   <= '0;
      sp_q   <= '0;
    end else if (launch) begin
      kind_q <= exc_kind_e'(kind_i);
      vec_q  <= vec_i;
      pc_q   <= pc_i;
      sr_q   <= sr_i;
      sp_q   <= sp_i;
    end
  end

  exc_seq_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ack_i    (mem_ack_i),
    .last_i   (last),
    .launch_o (launch),
    .fire_o   (fire),
    .req_o    (mem_req_o),
    .done_o   (done_o),
    .step_o   (step)
  );

  exc_seq_plan #(.XLEN(XLEN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_plan (
    .kind_i   (kind_q),
    .step_i   (step),
    .vec_i    (vec_q),
    .pc_i     (pc_q),
    .sr_i     (sr_q),
    .sp_i     (sp_q),
    .addr_o   (mem_addr_o),
    .we_o     (mem_we_o),
    .wdata_o  (mem_wdata_o),
    .dst_o    (dst),
    .last_o   (last),
    .sp_fin_o (sp_fin)
  );

  exc_seq_load #(.XLEN(XLEN)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .we_i     (mem_we_o),
    .dst_i    (dst),
    .rdata_i  (mem_rdata_i),
    .sp_set_i (fire && last && (kind_q == KIND_IRQ)),
    .sp_val_i (sp_fin),
    .pc_o     (pc_o),
    .sp_o     (sp_o)
  );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_ack_i,
  input logic            done_o
);
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  p_done_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i));

  p_launch_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !mem_req_o && !done_o |=> mem_req_o);
endmodule

bind exc_seq exc_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .done_o      (done_o)
);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
  localparam int          CLK_P    = 10;
  localparam int          XLEN     = 32;
  localparam int          VEC_W    = 8;
  localparam logic [31:0] VEC_BASE = 32'h0001_0000;
  localparam int          WDOG     = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] kind_i = '0;
  logic [VEC_W-1:0] vec_i = '0;
  logic [XLEN-1:0] pc_i = '0, sr_i = '0, sp_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0, done_o;
  logic [XLEN-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i, pc_o, sp_o;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction
  assign mem_rdata_i = mem_fn(mem_addr_o);

  exc_seq #(.XLEN(XLEN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .kind_i(kind_i),
    .vec_i(vec_i), .pc_i(pc_i), .sr_i(sr_i), .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .pc_o(pc_o), .sp_o(sp_o), .done_o(done_o)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] wdata;
    int          dst;
    string       tag;
  } acc_t;

  acc_t q[$];
  bit m_active = 0, m_done = 0, m_first = 0, m_irq = 0, m_ign = 0;
  logic [31:0] m_pc = '0, m_sp = '0, m_spfin = '0;
  string m_tag = "R1";
  int n_cmp = 0, n_bad = 0, ack_mode = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    chk(32'(mem_req_o), 32'(m_active), m_first ? "R9" : "R6", "mem_req_o");
    if (m_active && q.size() > 0) begin
      t = m_ign ? "R8" : q[0].tag;
      chk(32'(mem_we_o), 32'(q[0].we), t, "mem_we_o");
      chk(mem_addr_o, q[0].addr, t, "mem_addr_o");
      if (q[0].we) chk(mem_wdata_o, q[0].wdata, t, "mem_wdata_o");
    end
    chk(32'(done_o), 32'(m_done), "R7", "done_o");
    t = m_ign ? "R8" : m_tag;
    chk(pc_o, m_pc, t, "pc_o");
    chk(sp_o, m_sp, t, "sp_o");
  endtask

  task automatic model_step();
    bit nd = 0;
    if (start_i && (m_active || m_done)) m_ign = 1;
    if (m_active) begin
      m_first = 0;
      if (mem_ack_i) begin
        acc_t a = q.pop_front();
        if (!a.we) begin
          if (a.dst == 1) m_pc = mem_fn(a.addr);
          if (a.dst == 2) m_sp = mem_fn(a.addr);
        end
        if (q.size() == 0) begin
          m_active = 0;
          nd = 1;
          if (m_irq) m_sp = m_spfin;
        end
      end
    end else if (!m_done && start_i) begin
      m_ign = 0;
      m_active = 1;
      m_first = 1;
      m_irq = (kind_i == 2'd2);
      if (kind_i == 2'd2) begin
        m_tag = "R5";
        m_spfin = sp_i - 32'd8;
        q.push_back('{1, sp_i - 32'd4, sr_i, 0, "R4"});
        q.push_back('{1, sp_i - 32'd8, pc_i, 0, "R4"});
        q.push_back('{0, VEC_BASE + 32'(vec_i) * 32'd4, 32'd0, 1, "R5"});
      end else if (kind_i == 2'd1) begin
        m_tag = "R3";
        q.push_back('{0, VEC_BASE + 32'd8, 32'd0, 1, "R3"});
        q.push_back('{0, VEC_BASE + 32'd12, 32'd0, 2, "R3"});
      end else begin
        m_tag = "R2";
        q.push_back('{0, VEC_BASE, 32'd0, 1, "R2"});
        q.push_back('{0, VEC_BASE + 32'd4, 32'd0, 2, "R2"});
      end
    end
    m_done = nd;
  endtask

  task automatic cycle(input bit st, input logic [1:0] k, input logic [7:0] v,
                       input logic [31:0] p, input logic [31:0] s, input logic [31:0] spv);
    @(negedge clk);
    compare();
    start_i = st; kind_i = k; vec_i = v; pc_i = p; sr_i = s; sp_i = spv;
    mem_ack_i = (ack_mode == 0) ? 1'b1 : ($urandom_range(0, ack_mode) == 0);
    model_step();
  endtask

  // One sequence; noisy=1 keeps pulsing start with other inputs while busy (R8).
  task automatic run(input logic [1:0] k, input logic [7:0] v, input logic [31:0] p,
                     input logic [31:0] s, input logic [31:0] spv, input bit noisy);
    cycle(1, k, v, p, s, spv);
    while (m_active || m_done)
      cycle(noisy, ~k, ~v, ~p, ~s, spv ^ 32'h00F0_0000);
    cycle(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG);
      summary();
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    // R1: reset values
    chk(32'(mem_req_o), 0, "R1", "mem_req_o");
    chk(32'(done_o), 0, "R1", "done_o");
    chk(pc_o, 0, "R1", "pc_o");
    chk(sp_o, 0, "R1", "sp_o");
    rst_n = 1'b1;
    repeat (2) cycle(0, 0, 0, 0, 0, 0);

    ack_mode = 0;
    run(2'd0, 8'd0, 0, 0, 0, 0);                       // R2
    run(2'd1, 8'd0, 0, 0, 0, 0);                       // R3
    run(2'd2, 8'd5, 32'h1234_5678, 32'h0000_00F1, 32'h0000_8000, 0); // R4 R5
    ack_mode = 3;
    run(2'd3, 8'd9, 0, 0, 0, 0);                       // R2 reserved kind
    run(2'd2, 8'd255, 32'hDEAD_BEEF, 32'h7, 32'h0000_0004, 0);       // R5 wrap
    run(2'd1, 8'd0, 0, 0, 0, 1);                       // R8
    run(2'd2, 8'd17, 32'hCAFE_0000, 32'h3, 32'h2000_0010, 1);        // R8
    ack_mode = 0;
    run(2'd2, 8'd0, 32'h0000_0100, 32'h1, 32'hFFFF_FFF0, 1);         // R6 R9
    ack_mode = 5;
    for (int i = 0; i < 6; i++)
      run(2'(i % 3), 8'(i * 41), 32'h100 * i, 32'(i), 32'h4000 + 32'(i * 64), i[0]);
    repeat (3) cycle(1'b0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule